// File: doc/BRIEF.md
# ADC Conversion Start and Settling Sequencer

This block is the digital control sequencer of a delta-sigma converter front end. It runs on the modulator clock. It decides when the register file is being restored to its defaults, and when a conversion is running. It also counts out the filter settling time before the first valid result. After that it paces the active-low data-ready strobe at the output data rate. Conversions are requested by a level on a start pin or by decoded command strobes. A 3-bit rate code selects both the settling time and the data period. A mode bit selects continuous or single-shot operation.

The serial shifter, the filter arithmetic and the register storage sit outside this block. The command decoder presents each command as a one-cycle strobe. The register file raises a one-cycle write strobe whenever the rate register is written, with the new code already on `rate_code`. Downstream logic reads the result while `drdy_n` is low and may answer with `rd_ack`. All pins here are plain control levels or strobes, so there is no valid/ready flow and no back-pressure.

Top module: `adc_start_sequencer`

## Requirements
- R1: While `rst_n` is low, `drdy_n` is 1, `regs_load` is 1 and `filt_restart` is 0. After `rst_n` rises, `regs_load` stays 1 for exactly 18 rising clock edges. No conversion starts and `drdy_n` stays 1 during that time.
- R2: A `cmd_reset` strobe sampled at an edge restarts the same 18-edge default-load phase from that edge and clears the command run flag. `regs_load` is 1 and `drdy_n` is 1 after that edge.
- R3: When the start pin is low and no start command is pending, `drdy_n` stays 1.
- R4: The run request is `start_pin` OR a run flag. `cmd_start` sets the flag and `cmd_stop` clears it, with stop winning if both arrive together. If the run request drops while settling or converting, `drdy_n` is 1 after that edge and no further result appears.
- R5: When a conversion starts, `drdy_n` goes to 1 at the start edge. The first falling edge of `drdy_n` comes exactly (512 << c) + 9 clock edges later, where c is the rate code latched at the start edge (000 gives 521, 110 gives 32777). Code 111 behaves as 110.
- R6: In continuous mode (`single_shot` = 0), `drdy_n` falls again every 128 << c edges after the first result. It is 1 for exactly one cycle before each fall.
- R7: `rd_ack` sampled while `drdy_n` is 0 returns `drdy_n` to 1 after that edge, unless a new result lands on the same edge. `drdy_n` then stays 1 until the next result.
- R8: A `rate_wr` strobe while settling or converting restarts settling from that edge, using the code present on `rate_code`. `filt_restart` is a one-cycle pulse after every edge that starts settling and after every rate write outside the default-load phase.
- R9: In single-shot mode (`single_shot` = 1), one result is produced and the run flag is cleared. `drdy_n` stays 0 until `rd_ack` or a new start. No further result comes until the start pin goes low and high again, or a `cmd_start` arrives.
- R10: `cmd_start` while settling or converting restarts the settling count from that edge.
- R11: Start and stop commands sampled during the default-load phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| start_pin | input | 1 | Hardware start level |
| cmd_reset | input | 1 | Decoded reset command strobe |
| cmd_start | input | 1 | Decoded start command strobe |
| cmd_stop | input | 1 | Decoded stop command strobe |
| rate_wr | input | 1 | Write strobe of the rate-configuration register |
| rate_code | input | 3 | Data-rate code |
| single_shot | input | 1 | 1 selects single-shot, 0 continuous |
| rd_ack | input | 1 | Result read acknowledge |
| drdy_n | output | 1 | Data ready, active low |
| filt_restart | output | 1 | One-cycle digital filter restart pulse |
| regs_load | output | 1 | High while register defaults are being restored |

## Verification
The bench measures the edge count from the start to the first result for every rate code, including the reserved code. A sequencer that counted one data period instead of the settling time would fall hundreds of edges early. One that did not saturate code 111 would never produce a result in time. It times the gap between results and the one-cycle high gap, and checks that an acknowledge near a period boundary does not swallow the next result. It also checks that a rate write or a repeated start command in mid-settle restarts the count rather than being ignored. Finally, it covers single-shot operation with the pin still high, where a missing hold would produce a stream of results. It also covers a start command sent during the default-load phase, which a careless design would remember and act on after initialisation.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    SQ_INIT   = 2'd0,
    SQ_IDLE   = 2'd1,
    SQ_SETTLE = 2'd2,
    SQ_RUN    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adcseq_rate_timing.sv
module adcseq_rate_timing #(
  parameter int CODE_W         = 3,
  parameter int CNT_W          = 16,
  parameter int BASE_PERIOD    = 128,
  parameter int SETTLE_PERIODS = 4,
  parameter int SETTLE_EXTRA   = 9,
  parameter int MAX_CODE       = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  settle_last,
  output logic [CNT_W-1:0]  period_last,
  output logic [CNT_W-1:0]  period_pre
);
  localparam int ALL_CODES = 1 << CODE_W;
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(MAX_CODE);

  logic [CODE_W-1:0] eff_code;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  settle;

  // Saturate reserved codes only when the code space exceeds the legal range.
  generate
    if (MAX_CODE >= ALL_CODES - 1) begin : g_no_clamp
      assign eff_code = code;
    end else begin : g_clamp
      assign eff_code = (code > TOP_CODE) ? TOP_CODE : code;
    end
  endgenerate

  always_comb begin
    period      = CNT_W'(BASE_PERIOD) << eff_code;
    settle      = (period * CNT_W'(SETTLE_PERIODS)) + CNT_W'(SETTLE_EXTRA);
    settle_last = settle - CNT_W'(1);
    period_last = period - CNT_W'(1);
    period_pre  = period - CNT_W'(2);
  end
endmodule

// File: rtl/adcseq_run_ctrl.sv
module adcseq_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_init,
  input  logic start_pin,
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic ss_done,
  output logic run_keep,
  output logic go
);
  logic flag_q, flag_cmd, flag_d;
  logic hold_q, hold_d;

  always_comb begin
    if (in_init)        flag_cmd = 1'b0;
    else if (cmd_stop)  flag_cmd = 1'b0;
    else if (cmd_start) flag_cmd = 1'b1;
    else                flag_cmd = flag_q;

    run_keep = start_pin | flag_cmd;
    flag_d   = ss_done ? 1'b0 : flag_cmd;

    // hold blocks a fresh start after a single-shot result until the
    // request is withdrawn or a start command arrives
    if (in_init)        hold_d = 1'b0;
    else if (cmd_start) hold_d = 1'b0;
    else if (ss_done)   hold_d = 1'b1;
    else if (!run_keep) hold_d = 1'b0;
    else                hold_d = hold_q;

    go = run_keep & ~hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/adcseq_core.sv
module adcseq_core
  import adcseq_pkg::*;
#(
  parameter int CODE_W         = 3,
  parameter int CNT_W          = 16,
  parameter int INIT_CYCLES    = 18,
  parameter int BASE_PERIOD    = 128,
  parameter int SETTLE_PERIODS = 4,
  parameter int SETTLE_EXTRA   = 9,
  parameter int MAX_CODE       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_reset,
  input  logic              cmd_start,
  input  logic              rate_wr,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              single_shot,
  input  logic              rd_ack,
  input  logic              run_keep,
  input  logic              go,
  output seq_state_e        state,
  output logic              drdy_n,
  output logic              filt_restart,
  output logic              ss_done,
  output logic              res_evt,
  output logic              in_init
);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYCLES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  settle_last, period_last, period_pre;
  logic              restart, busy, settle_hit, period_hit;

  adcseq_rate_timing #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .BASE_PERIOD(BASE_PERIOD),
    .SETTLE_PERIODS(SETTLE_PERIODS), .SETTLE_EXTRA(SETTLE_EXTRA),
    .MAX_CODE(MAX_CODE)
  ) u_timing (
    .code(code_q), .settle_last(settle_last),
    .period_last(period_last), .period_pre(period_pre)
  );

  always_comb begin
    busy       = (state == SQ_SETTLE) || (state == SQ_RUN);
    restart    = cmd_start || rate_wr;
    settle_hit = (state == SQ_SETTLE) && (cnt_q == settle_last);
    period_hit = (state == SQ_RUN) && (cnt_q == period_last);
    in_init    = cmd_reset || (state == SQ_INIT);
    res_evt    = !cmd_reset && run_keep && !restart && (settle_hit || period_hit);
    ss_done    = res_evt && settle_hit && single_shot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SQ_INIT;
      cnt_q        <= '0;
      code_q       <= '0;
      drdy_n       <= 1'b1;
      filt_restart <= 1'b0;
    end else if (cmd_reset) begin
      state        <= SQ_INIT;
      cnt_q        <= '0;
      drdy_n       <= 1'b1;
      filt_restart <= 1'b0;
    end else begin
      filt_restart <= rate_wr && (state != SQ_INIT);
      unique case (state)
        SQ_INIT: begin
          drdy_n <= 1'b1;
          if (cnt_q == INIT_LAST) begin
            state <= SQ_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SQ_IDLE: begin
          if (go) begin
            state        <= SQ_SETTLE;
            cnt_q        <= '0;
            code_q       <= rate_code;
            drdy_n       <= 1'b1;
            filt_restart <= 1'b1;
          end else if (rd_ack) begin
            drdy_n <= 1'b1;
          end
        end
        default: begin
          if (busy && !run_keep) begin
            state  <= SQ_IDLE;
            cnt_q  <= '0;
            drdy_n <= 1'b1;
          end else if (restart) begin
            state        <= SQ_SETTLE;
            cnt_q        <= '0;
            code_q       <= rate_code;
            drdy_n       <= 1'b1;
            filt_restart <= 1'b1;
          end else if (settle_hit) begin
            drdy_n <= 1'b0;
            cnt_q  <= '0;
            state  <= single_shot ? SQ_IDLE : SQ_RUN;
          end else if (period_hit) begin
            drdy_n <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if ((state == SQ_RUN) && (cnt_q == period_pre)) drdy_n <= 1'b1;
            else if (rd_ack)                                 drdy_n <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_start_sequencer.sv
module adc_start_sequencer
  import adcseq_pkg::*;
#(
  parameter int CODE_W         = 3,
  parameter int CNT_W          = 16,
  parameter int INIT_CYCLES    = 18,
  parameter int BASE_PERIOD    = 128,
  parameter int SETTLE_PERIODS = 4,
  parameter int SETTLE_EXTRA   = 9,
  parameter int MAX_CODE       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pin,
  input  logic              cmd_reset,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              rate_wr,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              single_shot,
  input  logic              rd_ack,
  output logic              drdy_n,
  output logic              filt_restart,
  output logic              regs_load
);
  seq_state_e seq_state;
  logic       run_keep, go, ss_done, res_evt, in_init;

  adcseq_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .in_init(in_init), .start_pin(start_pin),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .ss_done(ss_done),
    .run_keep(run_keep), .go(go)
  );

  adcseq_core #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .INIT_CYCLES(INIT_CYCLES),
    .BASE_PERIOD(BASE_PERIOD), .SETTLE_PERIODS(SETTLE_PERIODS),
    .SETTLE_EXTRA(SETTLE_EXTRA), .MAX_CODE(MAX_CODE)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_start(cmd_start),
    .rate_wr(rate_wr), .rate_code(rate_code), .single_shot(single_shot),
    .rd_ack(rd_ack), .run_keep(run_keep), .go(go), .state(seq_state),
    .drdy_n(drdy_n), .filt_restart(filt_restart), .ss_done(ss_done),
    .res_evt(res_evt), .in_init(in_init)
  );

  assign regs_load = (seq_state == SQ_INIT);
endmodule

// File: rtl/adc_start_sequencer_chk.sv
module adc_start_sequencer_chk
  import adcseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_pin,
  input logic       cmd_reset,
  input logic       cmd_stop,
  input logic       rate_wr,
  input logic       rd_ack,
  input logic       drdy_n,
  input logic       filt_restart,
  input logic       regs_load,
  input seq_state_e seq_state,
  input logic       res_evt
);
  // R1: no result while defaults are being restored
  a_r1_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    regs_load |-> drdy_n);

  // R2: reset command enters the load phase with data-ready released
  a_r2_cmd_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (regs_load && drdy_n));

  // R4: withdrawing the run request while busy releases data-ready
  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !start_pin && (seq_state == SQ_SETTLE || seq_state == SQ_RUN))
      |=> drdy_n);

  // R5: data-ready is held high for the whole settling interval
  a_r5_settle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SQ_SETTLE) |-> drdy_n);

  // R7: acknowledge releases data-ready unless a new result lands
  a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !drdy_n && !res_evt && !regs_load) |=> drdy_n);

  // R8: every rate write outside the load phase restarts the filter
  a_r8_filt: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_wr && !regs_load && !cmd_reset) |=> filt_restart);
endmodule

bind adc_start_sequencer adc_start_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .cmd_reset(cmd_reset),
  .cmd_stop(cmd_stop), .rate_wr(rate_wr), .rd_ack(rd_ack), .drdy_n(drdy_n),
  .filt_restart(filt_restart), .regs_load(regs_load), .seq_state(seq_state),
  .res_evt(res_evt)
);

// File: tb/adc_start_sequencer_bench.sv
module adc_start_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam logic [2:0] VEC_CODE [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7};
  localparam int VEC_SETTLE [NVEC] = '{521, 1033, 2057, 4105, 8201, 16393, 32777};
  localparam int VEC_PERIOD [NVEC] = '{128, 256, 512, 1024, 2048, 4096, 8192};

  logic clk = 0, rst_n = 0, start_pin = 0, cmd_reset = 0, cmd_start = 0;
  logic cmd_stop = 0, rate_wr = 0, single_shot = 0, rd_ack = 0;
  logic [2:0] rate_code = 0;
  logic drdy_n, filt_restart, regs_load;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_start_sequencer u_adc_start_sequencer (
    .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .cmd_reset(cmd_reset),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .rate_wr(rate_wr),
    .rate_code(rate_code), .single_shot(single_shot), .rd_ack(rd_ack),
    .drdy_n(drdy_n), .filt_restart(filt_restart), .regs_load(regs_load)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic until_low(output int n, input int lim);
    n = 0;
    do begin tick(); n++; end while (drdy_n && n < lim);
  endtask

  task automatic until_load_done(output int n);
    n = 0;
    do begin tick(); n++; end while (regs_load && n < 100);
  endtask

  task automatic count_lows(output int lows, input int len);
    lows = 0;
    for (int i = 0; i < len; i++) begin tick(); if (!drdy_n) lows++; end
  endtask

  task automatic count_highs(output int highs, input int len);
    highs = 0;
    for (int i = 0; i < len; i++) begin tick(); if (drdy_n) highs++; end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, m, hi;
    // R1 reset state
    tick(); tick(); tick();
    chk(drdy_n == 1 && regs_load == 1 && filt_restart == 0, "R1 reset outputs",
        {drdy_n, regs_load, filt_restart}, 3'b110);
    rst_n = 1;
    until_load_done(n);
    chk(n == 18, "R1 load length", n, 18);
    // R3 nothing requested
    count_lows(m, 1000);
    chk(m == 0, "R3 idle without run", m, 0);

    // R5 R6 table of rate codes, pin driven, continuous
    for (int v = 0; v < NVEC; v++) begin
      rate_code = VEC_CODE[v];
      start_pin = 1;
      tick();
      chk(filt_restart == 1 && drdy_n == 1, "R8 start pulse", filt_restart, 1);
      until_low(n, 40000);
      chk(n == VEC_SETTLE[v], "R5 settle count", n, VEC_SETTLE[v]);
      m = 0; hi = 0;
      do begin tick(); m++; if (drdy_n) hi++; end
      while (!(drdy_n == 0 && hi > 0) && m < 10000);
      chk(m == VEC_PERIOD[v], "R6 period", m, VEC_PERIOD[v]);
      chk(hi == 1, "R6 high gap", hi, 1);
      start_pin = 0;
      tick();
      chk(drdy_n == 1, "R4 pin stop", drdy_n, 1);
      tick();
    end

    // R7 acknowledge
    rate_code = 0; start_pin = 1;
    until_low(n, 2000);
    rd_ack = 1; tick(); rd_ack = 0;
    chk(drdy_n == 1, "R7 ack release", drdy_n, 1);
    until_low(n, 2000);
    chk(n == 127, "R7 next result", n, 127);
    start_pin = 0; tick();
    count_lows(m, 300);
    chk(m == 0, "R4 stays stopped", m, 0);

    // R4 R10 command driven
    cmd_start = 1; tick(); cmd_start = 0;
    until_low(n, 2000);
    chk(n == 521, "R4 command start", n, 521);
    cmd_stop = 1; tick(); cmd_stop = 0;
    chk(drdy_n == 1, "R4 command stop", drdy_n, 1);
    count_lows(m, 700);
    chk(m == 0, "R4 no result after stop", m, 0);
    cmd_start = 1; tick(); cmd_start = 0;
    for (int i = 0; i < 300; i++) tick();
    cmd_start = 1; tick(); cmd_start = 0;
    until_low(n, 2000);
    chk(n == 521, "R10 restart by command", n, 521);
    cmd_stop = 1; tick(); cmd_stop = 0; tick();

    // R8 rate write mid-settle
    start_pin = 1; tick();
    for (int i = 0; i < 200; i++) tick();
    rate_code = 1; rate_wr = 1; tick(); rate_wr = 0;
    chk(filt_restart == 1, "R8 write pulse", filt_restart, 1);
    until_low(n, 3000);
    chk(n == 1033, "R8 settle restart", n, 1033);
    start_pin = 0; tick(); tick();

    // R9 single shot with pin held high
    rate_code = 0; single_shot = 1; start_pin = 1;
    until_low(n, 2000);
    chk(n == 522, "R9 single result", n, 522);
    count_highs(m, 600);
    chk(m == 0, "R9 held until ack", m, 0);
    rd_ack = 1; tick(); rd_ack = 0;
    count_lows(m, 800);
    chk(m == 0, "R9 no second result", m, 0);
    start_pin = 0; tick(); tick();
    start_pin = 1;
    until_low(n, 2000);
    chk(n == 522, "R9 re-armed by pin", n, 522);
    start_pin = 0; rd_ack = 1; tick(); rd_ack = 0; tick();
    cmd_start = 1; tick(); cmd_start = 0;
    until_low(n, 2000);
    chk(n == 521, "R9 command single shot", n, 521);
    count_highs(m, 800);
    chk(m == 0, "R9 command held", m, 0);
    rd_ack = 1; tick(); rd_ack = 0;
    single_shot = 0;

    // R2 reset command while running, R11 start during load
    cmd_start = 1; tick(); cmd_start = 0;
    for (int i = 0; i < 600; i++) tick();
    cmd_reset = 1; tick(); cmd_reset = 0;
    chk(regs_load == 1 && drdy_n == 1, "R2 reset command", {regs_load, drdy_n}, 2'b11);
    for (int i = 0; i < 4; i++) tick();
    cmd_start = 1; tick(); cmd_start = 0;
    n = 5;
    while (regs_load && n < 100) begin tick(); n++; end
    chk(n == 18, "R2 load length", n, 18);
    count_lows(m, 1000);
    chk(m == 0, "R11 start ignored in load", m, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule